// File: doc/BRIEF.md
# Transfer Kind Classifier and Path Chooser

This block sits between instruction decode and the transfer engine. For every transfer request it takes an opcode and a source and destination address, looks each address up in a programmable table of address ranges to learn whether it is local or global memory and which memory ID it belongs to, and from that works out the kind of transfer: a local copy, a load from global memory, a store to global memory, a send to another core or a receive from another core.

Once the kind is known, the block picks the path that will carry the data. Traffic to or from global memory and traffic between cores always goes over the inter-core bus. A local copy looks its resolved (source ID, destination ID) pair up in a second programmable table of dedicated links. On a hit it takes that dedicated link and reports which table slot matched. On a miss it falls back to the intra-core bus. Requests that cannot be placed, such as a copy between two global addresses, an address that no range covers, or a reserved opcode, come out with kind invalid and an error flag.

A request is accepted on a valid/ready handshake and its result appears one cycle later in an output register with its own valid/ready handshake. Both tables are loaded through simple write ports.

Top module: `xfer_route_dec`

## Requirements
- R1: After reset out_valid_o is 0, in_ready_o is 1, every range slot and every dedicated-pair slot is empty, so any request decodes as invalid.
- R2: An address hits range slot i when that slot is valid and base <= address <= limit (both ends inclusive). The hit gives the domain (1 = global, 0 = local) and the memory ID. When several slots hit, the lowest index wins. An unmapped address reports ID 0.
- R3: Opcode 0 (copy) decodes as kind 1 (local) for local to local, kind 2 (global load) for global to local, and kind 3 (global store) for local to global.
- R4: Opcode 1 decodes as kind 4 (send) and opcode 2 as kind 5 (receive), whatever the domains of the two addresses, provided both addresses are mapped.
- R5: A kind 1 result gets path 2 (dedicated) when a valid pair slot holds exactly its (source ID, destination ID). In that case ded_idx_o is the lowest matching slot index. Otherwise it gets path 1 (intra-core bus). ded_idx_o is 0 whenever the path is not 2.
- R6: Kinds 2, 3, 4 and 5 always get path 3 (inter-core bus).
- R7: A copy from global to global, any unmapped address, or opcode 3 gives kind 0, path 0 and err_o = 1. All other results have err_o = 0.
- R8: A request accepted on a rising edge shows up in the output register after that edge. in_ready_o equals !out_valid_o || out_ready_i. A result that is held while out_ready_i is low keeps all its fields unchanged.
- R9: A table write takes effect at the clock edge that samples it. Writing a pair slot with its valid bit at 0 removes that slot from matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rng_we_i | input | 1 | Range slot write enable |
| rng_idx_i | input | 3 | Range slot index |
| rng_vld_i | input | 1 | Range slot valid bit |
| rng_glob_i | input | 1 | Range domain, 1 = global |
| rng_base_i | input | 16 | Range first address |
| rng_limit_i | input | 16 | Range last address |
| rng_id_i | input | 4 | Range memory ID |
| pair_we_i | input | 1 | Pair slot write enable |
| pair_idx_i | input | 2 | Pair slot index |
| pair_vld_i | input | 1 | Pair slot valid bit |
| pair_src_i | input | 4 | Pair source memory ID |
| pair_dst_i | input | 4 | Pair destination memory ID |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Request accepted when high with in_valid_i |
| op_i | input | 2 | 0 copy, 1 send, 2 receive, 3 reserved |
| src_addr_i | input | 16 | Source address |
| dst_addr_i | input | 16 | Destination address |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Result consumer ready |
| kind_o | output | 3 | Transfer kind, 0 to 5 |
| path_o | output | 2 | 0 none, 1 intra-core, 2 dedicated, 3 inter-core |
| ded_idx_o | output | 2 | Matching dedicated pair slot |
| src_id_o | output | 4 | Resolved source memory ID |
| dst_id_o | output | 4 | Resolved destination memory ID |
| err_o | output | 1 | Request could not be placed |

## Verification
Copies are sent across every domain combination. Local-to-local, global-to-local and local-to-global copies must come out as different kinds, and global-to-global must raise the error flag. Send and receive use global addresses so that their kind cannot be mistaken for a copy kind. Addresses are placed on the first and last address of a range, one past the last, and inside a range that overlaps a lower slot, which separates inclusive from exclusive bounds and lowest-index priority from any other order. Local copies are chosen to hit a pair, miss it in reverse order, and hit a pair that is present in two slots. The same pair is then used again after its first slot has been cleared. A stream of requests with irregular output backpressure checks that results are held unchanged and none is lost or repeated.

// File: rtl/xfer_route_pkg.sv
package xfer_route_pkg;
  parameter int unsigned ADDR_W = 16;
  parameter int unsigned ID_W   = 4;

  typedef enum logic [1:0] {
    OP_COPY = 2'd0,
    OP_SEND = 2'd1,
    OP_RECV = 2'd2,
    OP_RSVD = 2'd3
  } xfer_op_e;

  typedef enum logic [2:0] {
    KIND_INVALID = 3'd0,
    KIND_LOCAL   = 3'd1,
    KIND_GLOAD   = 3'd2,
    KIND_GSTORE  = 3'd3,
    KIND_SEND    = 3'd4,
    KIND_RECV    = 3'd5
  } xfer_kind_e;

  typedef enum logic [1:0] {
    PATH_NONE  = 2'd0,
    PATH_INTRA = 2'd1,
    PATH_DEDIC = 2'd2,
    PATH_INTER = 2'd3
  } xfer_path_e;

  typedef struct packed {
    logic              vld;
    logic              glob;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic [ID_W-1:0]   id;
  } rng_ent_t;

  typedef struct packed {
    logic            vld;
    logic [ID_W-1:0] src;
    logic [ID_W-1:0] dst;
  } pair_ent_t;

  typedef struct packed {
    logic            hit;
    logic            glob;
    logic [ID_W-1:0] id;
  } rng_res_t;
endpackage

// File: rtl/xfer_cfg_tables.sv
module xfer_cfg_tables
  import xfer_route_pkg::*;
#(
  parameter int unsigned NUM_RNG    = 8,
  parameter int unsigned NUM_PAIR   = 4,
  parameter int unsigned RNG_IDX_W  = 3,
  parameter int unsigned PAIR_IDX_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rng_we_i,
  input  logic [RNG_IDX_W-1:0]  rng_idx_i,
  input  rng_ent_t              rng_wdata_i,
  input  logic                  pair_we_i,
  input  logic [PAIR_IDX_W-1:0] pair_idx_i,
  input  pair_ent_t             pair_wdata_i,
  output rng_ent_t              rng_tbl_o  [NUM_RNG],
  output pair_ent_t             pair_tbl_o [NUM_PAIR]
);
  for (genvar g = 0; g < NUM_RNG; g++) begin : g_rng
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rng_tbl_o[g] <= '0;
      end else if (rng_we_i && (rng_idx_i == RNG_IDX_W'(g))) begin
        rng_tbl_o[g] <= rng_wdata_i;
      end
    end
  end

  for (genvar g = 0; g < NUM_PAIR; g++) begin : g_pair
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pair_tbl_o[g] <= '0;
      end else if (pair_we_i && (pair_idx_i == PAIR_IDX_W'(g))) begin
        pair_tbl_o[g] <= pair_wdata_i;
      end
    end
  end
endmodule

// File: rtl/xfer_range_lookup.sv
module xfer_range_lookup
  import xfer_route_pkg::*;
#(
  parameter int unsigned NUM_RNG = 8
) (
  input  rng_ent_t          tbl_i [NUM_RNG],
  input  logic [ADDR_W-1:0] addr_i,
  output rng_res_t          res_o
);
  logic [NUM_RNG-1:0] hit;

  for (genvar g = 0; g < NUM_RNG; g++) begin : g_cmp
    assign hit[g] = tbl_i[g].vld &&
                    (addr_i >= tbl_i[g].base) &&
                    (addr_i <= tbl_i[g].limit);
  end

  // walk down so the lowest hitting slot is written last
  always_comb begin
    res_o = '0;
    for (int i = NUM_RNG - 1; i >= 0; i--) begin
      if (hit[i]) begin
        res_o.hit  = 1'b1;
        res_o.glob = tbl_i[i].glob;
        res_o.id   = tbl_i[i].id;
      end
    end
  end
endmodule

// File: rtl/xfer_pair_match.sv
module xfer_pair_match
  import xfer_route_pkg::*;
#(
  parameter int unsigned NUM_PAIR   = 4,
  parameter int unsigned PAIR_IDX_W = 2
) (
  input  pair_ent_t             tbl_i [NUM_PAIR],
  input  logic [ID_W-1:0]       src_id_i,
  input  logic [ID_W-1:0]       dst_id_i,
  output logic                  hit_o,
  output logic [PAIR_IDX_W-1:0] idx_o
);
  logic [NUM_PAIR-1:0] match;

  for (genvar g = 0; g < NUM_PAIR; g++) begin : g_cmp
    assign match[g] = tbl_i[g].vld &&
                      (tbl_i[g].src == src_id_i) &&
                      (tbl_i[g].dst == dst_id_i);
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_PAIR - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = PAIR_IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/xfer_classify.sv
module xfer_classify
  import xfer_route_pkg::*;
#(
  parameter int unsigned PAIR_IDX_W = 2
) (
  input  logic [1:0]            op_i,
  input  rng_res_t              src_res_i,
  input  rng_res_t              dst_res_i,
  input  logic                  pair_hit_i,
  input  logic [PAIR_IDX_W-1:0] pair_idx_i,
  output xfer_kind_e            kind_o,
  output xfer_path_e            path_o,
  output logic [PAIR_IDX_W-1:0] ded_idx_o,
  output logic                  err_o
);
  xfer_op_e   op;
  xfer_kind_e kind;

  assign op = xfer_op_e'(op_i);

  always_comb begin
    kind = KIND_INVALID;
    if (src_res_i.hit && dst_res_i.hit) begin
      unique case (op)
        OP_COPY: begin
          unique case ({src_res_i.glob, dst_res_i.glob})
            2'b00:   kind = KIND_LOCAL;
            2'b10:   kind = KIND_GLOAD;
            2'b01:   kind = KIND_GSTORE;
            default: kind = KIND_INVALID;
          endcase
        end
        OP_SEND: kind = KIND_SEND;
        OP_RECV: kind = KIND_RECV;
        default: kind = KIND_INVALID;
      endcase
    end
  end

  always_comb begin
    path_o    = PATH_NONE;
    ded_idx_o = '0;
    unique case (kind)
      KIND_INVALID: path_o = PATH_NONE;
      KIND_LOCAL: begin
        if (pair_hit_i) begin
          path_o    = PATH_DEDIC;
          ded_idx_o = pair_idx_i;
        end else begin
          path_o = PATH_INTRA;
        end
      end
      default: path_o = PATH_INTER;
    endcase
  end

  assign kind_o = kind;
  assign err_o  = (kind == KIND_INVALID);
endmodule

// File: rtl/xfer_route_dec.sv
module xfer_route_dec
  import xfer_route_pkg::*;
#(
  parameter int unsigned NUM_RNG  = 8,
  parameter int unsigned NUM_PAIR = 4,
  localparam int unsigned RNG_IDX_W  = (NUM_RNG  > 1) ? $clog2(NUM_RNG)  : 1,
  localparam int unsigned PAIR_IDX_W = (NUM_PAIR > 1) ? $clog2(NUM_PAIR) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rng_we_i,
  input  logic [RNG_IDX_W-1:0]  rng_idx_i,
  input  logic                  rng_vld_i,
  input  logic                  rng_glob_i,
  input  logic [ADDR_W-1:0]     rng_base_i,
  input  logic [ADDR_W-1:0]     rng_limit_i,
  input  logic [ID_W-1:0]       rng_id_i,
  input  logic                  pair_we_i,
  input  logic [PAIR_IDX_W-1:0] pair_idx_i,
  input  logic                  pair_vld_i,
  input  logic [ID_W-1:0]       pair_src_i,
  input  logic [ID_W-1:0]       pair_dst_i,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  input  logic [1:0]            op_i,
  input  logic [ADDR_W-1:0]     src_addr_i,
  input  logic [ADDR_W-1:0]     dst_addr_i,
  output logic                  out_valid_o,
  input  logic                  out_ready_i,
  output logic [2:0]            kind_o,
  output logic [1:0]            path_o,
  output logic [PAIR_IDX_W-1:0] ded_idx_o,
  output logic [ID_W-1:0]       src_id_o,
  output logic [ID_W-1:0]       dst_id_o,
  output logic                  err_o
);
  rng_ent_t  rng_wdata;
  pair_ent_t pair_wdata;
  rng_ent_t  rng_tbl  [NUM_RNG];
  pair_ent_t pair_tbl [NUM_PAIR];

  assign rng_wdata  = '{vld: rng_vld_i, glob: rng_glob_i, base: rng_base_i,
                        limit: rng_limit_i, id: rng_id_i};
  assign pair_wdata = '{vld: pair_vld_i, src: pair_src_i, dst: pair_dst_i};

  xfer_cfg_tables #(
    .NUM_RNG    (NUM_RNG),
    .NUM_PAIR   (NUM_PAIR),
    .RNG_IDX_W  (RNG_IDX_W),
    .PAIR_IDX_W (PAIR_IDX_W)
  ) tables_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rng_we_i     (rng_we_i),
    .rng_idx_i    (rng_idx_i),
    .rng_wdata_i  (rng_wdata),
    .pair_we_i    (pair_we_i),
    .pair_idx_i   (pair_idx_i),
    .pair_wdata_i (pair_wdata),
    .rng_tbl_o    (rng_tbl),
    .pair_tbl_o   (pair_tbl)
  );

  rng_res_t src_res, dst_res;

  xfer_range_lookup #(.NUM_RNG(NUM_RNG)) src_lkp_i (
    .tbl_i  (rng_tbl),
    .addr_i (src_addr_i),
    .res_o  (src_res)
  );

  xfer_range_lookup #(.NUM_RNG(NUM_RNG)) dst_lkp_i (
    .tbl_i  (rng_tbl),
    .addr_i (dst_addr_i),
    .res_o  (dst_res)
  );

  logic                  pair_hit;
  logic [PAIR_IDX_W-1:0] pair_idx;

  xfer_pair_match #(
    .NUM_PAIR   (NUM_PAIR),
    .PAIR_IDX_W (PAIR_IDX_W)
  ) pair_i (
    .tbl_i    (pair_tbl),
    .src_id_i (src_res.id),
    .dst_id_i (dst_res.id),
    .hit_o    (pair_hit),
    .idx_o    (pair_idx)
  );

  xfer_kind_e            kind_d;
  xfer_path_e            path_d;
  logic [PAIR_IDX_W-1:0] ded_idx_d;
  logic                  err_d;

  xfer_classify #(.PAIR_IDX_W(PAIR_IDX_W)) cls_i (
    .op_i       (op_i),
    .src_res_i  (src_res),
    .dst_res_i  (dst_res),
    .pair_hit_i (pair_hit),
    .pair_idx_i (pair_idx),
    .kind_o     (kind_d),
    .path_o     (path_d),
    .ded_idx_o  (ded_idx_d),
    .err_o      (err_d)
  );

  logic out_valid_q;
  logic load;

  assign in_ready_o = !out_valid_q || out_ready_i;
  assign load       = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      kind_o      <= '0;
      path_o      <= '0;
      ded_idx_o   <= '0;
      src_id_o    <= '0;
      dst_id_o    <= '0;
      err_o       <= 1'b0;
    end else begin
      if (in_ready_o) out_valid_q <= in_valid_i;
      if (load) begin
        kind_o    <= kind_d;
        path_o    <= path_d;
        ded_idx_o <= ded_idx_d;
        src_id_o  <= src_res.id;
        dst_id_o  <= dst_res.id;
        err_o     <= err_d;
      end
    end
  end

  assign out_valid_o = out_valid_q;
endmodule

// File: rtl/xfer_route_dec_chk.sv
module xfer_route_dec_chk #(
  parameter int unsigned PAIR_IDX_W = 2,
  parameter int unsigned ID_W       = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  in_valid_i,
  input logic                  in_ready_o,
  input logic                  out_valid_o,
  input logic                  out_ready_i,
  input logic [2:0]            kind_o,
  input logic [1:0]            path_o,
  input logic [PAIR_IDX_W-1:0] ded_idx_o,
  input logic [ID_W-1:0]       src_id_o,
  input logic [ID_W-1:0]       dst_id_o,
  input logic                  err_o
);
  // R8
  accept_to_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  // R8
  empty_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);

  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(kind_o) &&
      $stable(path_o) && $stable(ded_idx_o) && $stable(src_id_o) &&
      $stable(dst_id_o) && $stable(err_o)));

  // R7
  err_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (err_o == (kind_o == 3'd0)));

  // R7
  err_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && err_o) |-> (path_o == 2'd0));

  // R6
  inter_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (kind_o >= 3'd2) && (kind_o <= 3'd5)) |-> (path_o == 2'd3));

  // R5
  local_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (kind_o == 3'd1)) |-> ((path_o == 2'd1) || (path_o == 2'd2)));

  // R5
  ded_idx_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (path_o != 2'd2)) |-> (ded_idx_o == '0));
endmodule

bind xfer_route_dec xfer_route_dec_chk #(
  .PAIR_IDX_W (PAIR_IDX_W),
  .ID_W       (xfer_route_pkg::ID_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .kind_o      (kind_o),
  .path_o      (path_o),
  .ded_idx_o   (ded_idx_o),
  .src_id_o    (src_id_o),
  .dst_id_o    (dst_id_o),
  .err_o       (err_o)
);

// File: tb/xfer_route_dec_tb.sv
module xfer_route_dec_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;
  localparam int NR = 8;
  localparam int NP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rng_we = 1'b0;
  logic [2:0]  rng_idx = '0;
  logic        rng_vld = 1'b0;
  logic        rng_glob = 1'b0;
  logic [15:0] rng_base = '0;
  logic [15:0] rng_limit = '0;
  logic [3:0]  rng_id = '0;
  logic        pair_we = 1'b0;
  logic [1:0]  pair_idx = '0;
  logic        pair_vld = 1'b0;
  logic [3:0]  pair_src = '0;
  logic [3:0]  pair_dst = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  op = '0;
  logic [15:0] src_addr = '0;
  logic [15:0] dst_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  kind;
  logic [1:0]  path;
  logic [1:0]  ded_idx;
  logic [3:0]  src_id;
  logic [3:0]  dst_id;
  logic        err;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_route_dec dut_i (
    .clk_i (clk), .rst_ni (rst_n),
    .rng_we_i (rng_we), .rng_idx_i (rng_idx), .rng_vld_i (rng_vld),
    .rng_glob_i (rng_glob), .rng_base_i (rng_base), .rng_limit_i (rng_limit),
    .rng_id_i (rng_id),
    .pair_we_i (pair_we), .pair_idx_i (pair_idx), .pair_vld_i (pair_vld),
    .pair_src_i (pair_src), .pair_dst_i (pair_dst),
    .in_valid_i (in_valid), .in_ready_o (in_ready), .op_i (op),
    .src_addr_i (src_addr), .dst_addr_i (dst_addr),
    .out_valid_o (out_valid), .out_ready_i (out_ready),
    .kind_o (kind), .path_o (path), .ded_idx_o (ded_idx),
    .src_id_o (src_id), .dst_id_o (dst_id), .err_o (err)
  );

  // behavioural model state
  bit          m_rv [NR];
  bit          m_rg [NR];
  int          m_rb [NR];
  int          m_rl [NR];
  int          m_rid[NR];
  bit          m_pv [NP];
  int          m_ps [NP];
  int          m_pd [NP];

  typedef struct packed {
    logic [2:0] kind;
    logic [1:0] path;
    logic [1:0] idx;
    logic [3:0] sid;
    logic [3:0] did;
    logic       err;
  } exp_t;

  exp_t eq[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   cyc = 0;
  bit   bp = 1'b0;
  bit   done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic void resolve(input int a, output bit hit, output bit g, output int id);
    hit = 0; g = 0; id = 0;
    for (int i = 0; i < NR; i++) begin
      if (!hit && m_rv[i] && a >= m_rb[i] && a <= m_rl[i]) begin
        hit = 1; g = m_rg[i]; id = m_rid[i];
      end
    end
  endfunction

  function automatic exp_t model(input int o, input int s, input int d);
    exp_t e;
    bit sh, sg, dh, dg;
    int si, di;
    resolve(s, sh, sg, si);
    resolve(d, dh, dg, di);
    e = '0;
    e.sid = si[3:0];
    e.did = di[3:0];
    if (!sh || !dh)             e.kind = 3'd0;
    else if (o == 1)            e.kind = 3'd4;
    else if (o == 2)            e.kind = 3'd5;
    else if (o == 3)            e.kind = 3'd0;
    else if (!sg && !dg)        e.kind = 3'd1;
    else if (sg && !dg)         e.kind = 3'd2;
    else if (!sg && dg)         e.kind = 3'd3;
    else                        e.kind = 3'd0;
    e.err = (e.kind == 3'd0);
    if (e.kind == 3'd0) e.path = 2'd0;
    else if (e.kind == 3'd1) begin
      e.path = 2'd1;
      for (int j = NP - 1; j >= 0; j--) begin
        if (m_pv[j] && m_ps[j] == si && m_pd[j] == di) begin
          e.path = 2'd2; e.idx = 2'(j);
        end
      end
    end else e.path = 2'd3;
    return e;
  endfunction

  // reference comparison on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      // R8 ready rule
      chk(in_ready == (!out_valid || out_ready), "R8 in_ready", in_ready, !out_valid || out_ready);
      if (out_valid) begin
        if (eq.size() == 0) begin
          chk(1'b0, "R8 unexpected result", 1, 0);
        end else begin
          chk(kind == eq[0].kind, "R3/R4/R7 kind", kind, eq[0].kind);
          chk(path == eq[0].path, "R5/R6 path", path, eq[0].path);
          chk(ded_idx == eq[0].idx, "R5 ded_idx", ded_idx, eq[0].idx);
          chk(src_id == eq[0].sid, "R2 src_id", src_id, eq[0].sid);
          chk(dst_id == eq[0].did, "R2 dst_id", dst_id, eq[0].did);
          chk(err == eq[0].err, "R7 err", err, eq[0].err);
          if (out_ready) void'(eq.pop_front());
        end
      end
      if (in_valid && in_ready) eq.push_back(model(op, src_addr, dst_addr));
      // R9 model tables follow the same edge as the design
      if (rng_we) begin
        m_rv[rng_idx] = rng_vld; m_rg[rng_idx] = rng_glob;
        m_rb[rng_idx] = rng_base; m_rl[rng_idx] = rng_limit; m_rid[rng_idx] = rng_id;
      end
      if (pair_we) begin
        m_pv[pair_idx] = pair_vld; m_ps[pair_idx] = pair_src; m_pd[pair_idx] = pair_dst;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      chk(1'b0, "watchdog", cyc, WD_LIMIT);
      finish_run();
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = bp ? ((cyc % 3) != 1) : 1'b1;
    end
  end

  task automatic set_rng(input int i, input bit g, input int b, input int l, input int id);
    @(posedge clk); #1;
    rng_we = 1; rng_idx = 3'(i); rng_vld = 1; rng_glob = g;
    rng_base = 16'(b); rng_limit = 16'(l); rng_id = 4'(id);
    @(posedge clk); #1;
    rng_we = 0;
  endtask

  task automatic set_pair(input int i, input bit v, input int s, input int d);
    @(posedge clk); #1;
    pair_we = 1; pair_idx = 2'(i); pair_vld = v; pair_src = 4'(s); pair_dst = 4'(d);
    @(posedge clk); #1;
    pair_we = 0;
  endtask

  // inputs are changed 1 time unit after a rising edge
  task automatic xfer(input int o, input int s, input int d);
    in_valid = 1; op = 2'(o); src_addr = 16'(s); dst_addr = 16'(d);
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic drain();
    bp = 0;
    repeat (4) @(posedge clk);
    #2;
    chk(eq.size() == 0, "R8 all results delivered", eq.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < NR; i++) begin
      m_rv[i] = 0; m_rg[i] = 0; m_rb[i] = 0; m_rl[i] = 0; m_rid[i] = 0;
    end
    for (int i = 0; i < NP; i++) begin
      m_pv[i] = 0; m_ps[i] = 0; m_pd[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
    @(posedge clk); #1;
    rst_n = 1;
    @(posedge clk); #1;
    // R1 empty tables: everything decodes invalid
    xfer(0, 16'h0010, 16'h0020);
    xfer(1, 16'h9000, 16'h0000);
    drain();

    // ranges: slot 3 overlaps slot 0 and must lose (R2)
    set_rng(0, 0, 16'h0000, 16'h0FFF, 1);
    set_rng(1, 0, 16'h1000, 16'h1FFF, 2);
    set_rng(2, 1, 16'h8000, 16'hFFFF, 9);
    set_rng(3, 0, 16'h0800, 16'h08FF, 5);
    set_rng(4, 0, 16'h2000, 16'h2FFF, 3);
    set_rng(5, 1, 16'h3000, 16'h3FFF, 7);
    set_rng(6, 0, 16'h5000, 16'h50FF, 5);
    // pairs: (1,2) in slots 1 and 3, (2,3) in slot 0 (R5)
    set_pair(0, 1, 2, 3);
    set_pair(1, 1, 1, 2);
    set_pair(3, 1, 1, 2);

    // R3 copy kinds, R5 path choice
    xfer(0, 16'h0010, 16'h1010);   // local (1,2) dedicated slot 1
    xfer(0, 16'h1000, 16'h0000);   // local (2,1) intra
    xfer(0, 16'h1FFF, 16'h2FFF);   // local (2,3) dedicated slot 0, limits
    xfer(0, 16'h0880, 16'h5000);   // R2 overlap: id 1 not 5 -> (1,5) intra
    xfer(0, 16'h9000, 16'h0100);   // global load
    xfer(0, 16'h0100, 16'h3000);   // global store
    // R6/R4
    xfer(1, 16'h9000, 16'h3FFF);   // send
    xfer(2, 16'h3000, 16'h8000);   // receive
    // R7 errors
    xfer(0, 16'h9000, 16'h3000);   // global to global
    xfer(0, 16'h4000, 16'h0000);   // one past slot 5 limit, unmapped
    xfer(0, 16'h0000, 16'h5100);   // unmapped destination
    xfer(3, 16'h0000, 16'h1000);   // reserved opcode
    drain();

    // R9 clearing pair slot 1 moves the match to slot 3
    set_pair(1, 0, 1, 2);
    xfer(0, 16'h0000, 16'h1000);
    // R9 clearing slot 3 too falls back to intra
    set_pair(3, 0, 1, 2);
    xfer(0, 16'h0000, 16'h1000);
    drain();

    // R8 stream under backpressure
    bp = 1;
    for (int k = 0; k < 40; k++) begin
      case (k % 8)
        0: xfer(0, 16'h0004 + k, 16'h2004);
        1: xfer(0, 16'h1004, 16'h2FF0);
        2: xfer(0, 16'hA000, 16'h1100);
        3: xfer(0, 16'h1100, 16'hFFFF);
        4: xfer(1, 16'h0000, 16'h8000);
        5: xfer(2, 16'h8000, 16'h0000);
        6: xfer(0, 16'hF000, 16'hE000);
        default: xfer(3, 16'h0000, 16'h0000);
      endcase
    end
    drain();
    finish_run();
  end
endmodule